// File: doc/BRIEF.md
# Occupancy-Gated Ten-Stage Add Pipeline

The block is a ten-stage arithmetic pipeline in which every stage's register loads only while an operation is actually passing through that stage. A one-hot-per-operation occupancy register runs beside the datapath. An accepted submission injects a token into its lowest bit, and the token then moves one position per clock. Each stage uses its token bit as a load enable. Idle stages therefore hold their contents and do not toggle. The datapath has no pass-through multiplexers: every operation crosses all ten registers.

Each stage adds a fixed constant equal to its index plus one. A result is therefore the operand plus 55, modulo 2^DW. A mode input selects full-rate issue (one operation per cycle) or half-rate issue. In half-rate mode a submission in the cycle right after an accepted one is refused. Operations in flight then occupy alternate stages, so odd and even stages take turns loading. The block has no stall and no backpressure. Results leave in submission order, a fixed number of cycles after acceptance.

Top module: `occ_gated_pipe`

## Requirements
- R1: A synchronous active-high reset clears every occupancy bit and `result_vld_o`. `result_vld_o` reads 0 in the first cycle after reset.
- R2: With `half_rate_i` = 0, every cycle with `issue_i` = 1 has `accept_o` = 1 in that same cycle.
- R3: An accepted operand X produces the result (X + 55) mod 2^DW on `result_o`. The 55 is the sum of the per-stage constants 1 through 10, and the result wraps at 2^DW (for example 16'hFFC9 yields 16'h0000).
- R4: The accepting clock edge is edge 0. `result_vld_o` is 1 in the cycle after edge 10 and carries that operation's result.
- R5: Accepted operations on consecutive cycles yield results on consecutive cycles, in submission order.
- R6: With `half_rate_i` = 1, a submission in the cycle right after a cycle with an accepted submission has `accept_o` = 0 and never produces a result.
- R7: With `half_rate_i` = 1, a submission at least one idle cycle after the last acceptance is accepted.
- R8: A stage whose occupancy bit is clear keeps its contents. In particular, `result_o` does not change in any cycle where `result_vld_o` is 0.
- R9: A reset asserted while operations are in flight discards them. No `result_vld_o` pulse follows for those operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Submission strobe |
| operand_i | input | DW | Operand of the submission |
| half_rate_i | input | 1 | 1 selects half-rate issue, 0 selects full rate |
| accept_o | output | 1 | The submission in this cycle is taken |
| result_o | output | DW | Output of the last stage |
| result_vld_o | output | 1 | `result_o` holds a new result |

## Verification
On every cycle, the assertions check these rules: immediate acceptance in full-rate mode; refusal of an adjacent submission in half-rate mode; the ten-edge link between token and valid; stage registers holding while their enable is low; and the cleared state after reset. Only the bench's scenarios can show the end-to-end behaviour. This covers the arithmetic result and its wraparound, in-order delivery of back-to-back and mixed-rate streams, refused operations leaving no trace, and in-flight work vanishing on reset.

// File: rtl/occ_pipe_pkg.sv
package occ_pipe_pkg;
  localparam int DEF_STAGES = 10;
  localparam int DEF_DW     = 16;

  // Constant added by stage k (0-based).
  function automatic int unsigned stage_const(input int k);
    return k + 1;
  endfunction

  // Total offset after n stages.
  function automatic int unsigned total_offset(input int n);
    int unsigned s;
    s = 0;
    for (int k = 0; k < n; k++) s += stage_const(k);
    return s;
  endfunction
endpackage

// File: rtl/issue_gate.sv
module issue_gate (
  input  logic clk,
  input  logic rst,
  input  logic issue_i,
  input  logic half_i,
  output logic accept_o
);
  logic took_last_q;

  // Half-rate mode refuses a submission adjacent to the previous accepted one.
  assign accept_o = issue_i & ~(half_i & took_last_q);

  always_ff @(posedge clk) begin
    if (rst) took_last_q <= 1'b0;
    else     took_last_q <= accept_o;
  end

  // R6: two accepted half-rate submissions are never adjacent
  a_r6_no_adjacent: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> !(half_i && accept_o));
endmodule

// File: rtl/occ_shift.sv
module occ_shift #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inject_i,
  output logic [N-1:0] occ_o
);
  logic [N-1:0] occ_q;

  always_ff @(posedge clk) begin
    if (rst) occ_q <= '0;
    else     occ_q <= {occ_q[N-2:0], inject_i};
  end

  assign occ_o = occ_q;

  // R1: the register is empty right after reset
  a_r1_occ_cleared: assert property (@(posedge clk)
    rst |=> (occ_q == '0));
endmodule

// File: rtl/gated_stage.sv
module gated_stage #(
  parameter int DW = 16,
  parameter int K  = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  import occ_pipe_pkg::*;

  localparam logic [DW-1:0] ADDEND = DW'(stage_const(K));

  logic [DW-1:0] q_q;

  always_ff @(posedge clk) begin
    if (en_i) q_q <= d_i + ADDEND;
  end

  assign q_o = q_q;

  // R8: an unoccupied stage holds its value
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(q_q));
endmodule

// File: rtl/occ_gated_pipe.sv
module occ_gated_pipe #(
  parameter int STAGES = occ_pipe_pkg::DEF_STAGES,
  parameter int DW     = occ_pipe_pkg::DEF_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_i,
  input  logic [DW-1:0] operand_i,
  input  logic          half_rate_i,
  output logic          accept_o,
  output logic [DW-1:0] result_o,
  output logic          result_vld_o
);
  localparam int LAST = STAGES - 1;

  logic              accepted_ev;
  logic [STAGES-1:0] occ;
  logic [DW-1:0]     in_q;
  logic [DW-1:0]     stage_q [STAGES];
  logic              last_fire_ev;
  logic              vld_q;

  issue_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .issue_i  (issue_i),
    .half_i   (half_rate_i),
    .accept_o (accepted_ev)
  );

  occ_shift #(.N(STAGES)) u_occ (
    .clk      (clk),
    .rst      (rst),
    .inject_i (accepted_ev),
    .occ_o    (occ)
  );

  // Operand capture, loaded only on acceptance.
  always_ff @(posedge clk) begin
    if (accepted_ev) in_q <= operand_i;
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic [DW-1:0] src;
    if (k == 0) begin : g_first
      assign src = in_q;
    end else begin : g_rest
      assign src = stage_q[k-1];
    end
    gated_stage #(.DW(DW), .K(k)) u_stage (
      .clk  (clk),
      .rst  (rst),
      .en_i (occ[k]),
      .d_i  (src),
      .q_o  (stage_q[k])
    );
  end

  assign last_fire_ev = occ[LAST];

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= last_fire_ev;
  end

  assign accept_o     = accepted_ev;
  assign result_o     = stage_q[LAST];
  assign result_vld_o = vld_q;

  // R1: valid is low after reset
  a_r1_vld_cleared: assert property (@(posedge clk)
    rst |=> !result_vld_o);

  // R2: full-rate mode takes every submission
  a_r2_full_rate: assert property (@(posedge clk) disable iff (rst)
    (!half_rate_i && issue_i) |-> accept_o);

  // R4: valid follows the token that sat in the second-to-last stage two edges earlier
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    result_vld_o |-> $past(occ[LAST-1], 2));

  // R8: result holds whenever no new result is flagged
  a_r8_result_holds: assert property (@(posedge clk) disable iff (rst)
    !last_fire_ev |=> $stable(result_o));
endmodule

// File: tb/occ_gated_pipe_tb_top.sv
module occ_gated_pipe_tb_top;
  localparam int STAGES = 10;
  localparam int DW     = 16;
  localparam int LAT    = STAGES + 1;
  localparam int RING   = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          issue_i;
  logic [DW-1:0] operand_i;
  logic          half_rate_i;
  logic          accept_o;
  logic [DW-1:0] result_o;
  logic          result_vld_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  occ_gated_pipe #(.STAGES(STAGES), .DW(DW)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .issue_i      (issue_i),
    .operand_i    (operand_i),
    .half_rate_i  (half_rate_i),
    .accept_o     (accept_o),
    .result_o     (result_o),
    .result_vld_o (result_vld_o)
  );

  // Bench model state.
  bit            exp_vld [RING];
  logic [DW-1:0] exp_dat [RING];
  int            cyc = 0;
  bit            prev_acc = 0;
  bit            have_last = 0;
  logic [DW-1:0] last_res;
  logic [15:0]   lfsr = 16'hACE1;

  function automatic logic [DW-1:0] model_result(input logic [DW-1:0] x);
    int unsigned off;
    off = STAGES * (STAGES + 1) / 2;
    return DW'((int'(x) + off) % (1 << DW));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < RING; i++) exp_vld[i] = 0;
    prev_acc = 0;
  endtask

  task automatic tick(input bit iss, input logic [DW-1:0] op, input bit hr);
    bit want_acc;
    issue_i = iss; operand_i = op; half_rate_i = hr;
    #1;
    want_acc = iss && !(hr && prev_acc);
    if (iss) begin
      if (hr) chk(accept_o == want_acc, want_acc ? "R7" : "R6", accept_o, want_acc);
      else    chk(accept_o == want_acc, "R2", accept_o, want_acc);
    end
    if (want_acc) begin
      exp_vld[(cyc + LAT) % RING] = 1;
      exp_dat[(cyc + LAT) % RING] = model_result(op);
    end
    prev_acc = want_acc;
    @(posedge clk);
    #2;
    cyc++;
    chk(result_vld_o == exp_vld[cyc % RING], "R4/R5", result_vld_o, exp_vld[cyc % RING]);
    if (exp_vld[cyc % RING] && result_vld_o) begin
      chk(result_o == exp_dat[cyc % RING], "R3", result_o, exp_dat[cyc % RING]);
      last_res  = result_o;
      have_last = 1;
    end else if (have_last && !result_vld_o) begin
      chk(result_o == last_res, "R8", result_o, last_res);
    end
    exp_vld[cyc % RING] = 0;
  endtask

  task automatic do_reset();
    rst = 1; issue_i = 0; operand_i = '0; half_rate_i = 0;
    repeat (2) @(posedge clk);
    #2;
    rst = 0;
    clear_model();
    chk(result_vld_o == 1'b0, "R1", result_vld_o, 0);
  endtask

  initial begin
    do_reset();
    // R2, R3, R5: back-to-back full-rate stream with boundary operands
    tick(1, 16'hFFC9, 0);
    tick(1, 16'hFFFF, 0);
    tick(1, 16'h0000, 0);
    tick(1, 16'hFFC8, 0);
    for (int i = 0; i < 40; i++) tick(1, DW'(i * 1637 + 3), 0);
    repeat (14) tick(0, '0, 0);
    // R6: half-rate with issue every cycle, alternate ones refused
    for (int i = 0; i < 30; i++) tick(1, DW'(i * 97), 1);
    repeat (14) tick(0, '0, 1);
    // R7: half-rate with gaps of one and two idle cycles
    for (int i = 0; i < 12; i++) begin
      tick(1, DW'(16'hFFC0 + i), 1);
      tick(0, '0, 1);
      if (i % 2 == 1) tick(0, '0, 1);
    end
    repeat (14) tick(0, '0, 1);
    // Mode switch: full-rate accept followed by a half-rate issue (R6)
    tick(1, 16'h1234, 0);
    tick(1, 16'h4321, 1);
    repeat (14) tick(0, '0, 0);
    // R9: reset with operations in flight
    for (int i = 0; i < 5; i++) tick(1, DW'(i + 7), 0);
    do_reset();
    for (int i = 0; i < 14; i++) tick(0, '0, 0);
    // Mixed pseudo-random sweep
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick(lfsr[0] | lfsr[3], DW'(lfsr * 16'd3), lfsr[5] & lfsr[7]);
    end
    repeat (14) tick(0, '0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule